// File: doc/BRIEF.md
# External Bus Chip-Select Sequencer

This block drives the external address outputs and a set of active-low chip-select lines of a microcontroller-style bus interface. The bus master offers one request per bus cycle: nothing, an internal access (special-function registers or on-chip memory), or an external read or write with an address. The sequencer registers the result, so the outputs take their new values on the clock edge after the request.

External addresses are split into equal, contiguous regions by their top bits, and each region owns one chip-select line. The address outputs and each chip-select decide separately whether to change, based on what the current request targets and on what the previous cycles left behind. A chip-select stays low across back-to-back accesses to its region. The address outputs stay frozen through internal and idle cycles. A read strobe and a write strobe mark the external cycles and give their direction.

Top module: `extbus_cs_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first edge after it, all `csN` lines are high, `busAddr` is zero and both strobes are low. No region counts as selected, so a following idle cycle keeps every `csN` high.
- R2: An external request (`reqValid` high, `reqKind` 10 or 11) with no region selected loads `reqAddr` into `busAddr` on the next edge. It also drives low the one `csN` bit whose index equals `reqAddr[23:22]`.
- R3: An external request to the region that is already selected loads the new address into `busAddr`. That region's `csN` bit stays low through the edge and never goes high in between.
- R4: An external request to a region other than the selected one loads the new address. On the same edge it raises the old region's `csN` bit and lowers the new region's bit.
- R5: An internal request (`reqKind` 01) raises every `csN` bit on the next edge and leaves `busAddr` at the last external address.
- R6: An idle cycle (`reqKind` 00, or `reqValid` low with any kind) leaves `busAddr` and all `csN` bits unchanged. This holds whether a region is selected or not.
- R7: At most one `csN` bit is low in any cycle.
- R8: `rdStrobe` is high for exactly the cycle after an external read (10). `wrStrobe` is high for exactly the cycle after an external write (11). Both are low after internal and idle cycles, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | 00 idle, 01 internal, 10 external read, 11 external write |
| reqAddr | input | ADDR_W (24) | External address of the request |
| busAddr | output | ADDR_W (24) | Registered external address outputs |
| csN | output | NUM_CS (4) | Registered chip-selects, active low, one per region |
| rdStrobe | output | 1 | High during an external read cycle |
| wrStrobe | output | 1 | High during an external write cycle |

## Verification
The hardest case to reach from the ports is a chip-select that must stay low across a mix of idle cycles and same-region accesses. A close second is an idle cycle that follows an internal access, where nothing may come back on. Directed sequences build these chains on purpose: repeated accesses to one region with idle gaps, a switch of region, an internal access followed by idles, and a request whose kind is external but whose valid is low. A long random run follows, in which about one request in eight is invalid, so the same cases also come up in many other orders. A behavioural model tracks the expected address, selected region and strobes, and the outputs are compared with it on every cycle.

// File: rtl/ebcs_pkg.sv
package ebcs_pkg;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'b00,
    KIND_INT    = 2'b01,
    KIND_EXT_RD = 2'b10,
    KIND_EXT_WR = 2'b11
  } reqKind_e;

  typedef enum logic [1:0] {
    CS_HOLD   = 2'b00,
    CS_CLEAR  = 2'b01,
    CS_SELECT = 2'b10
  } csAct_e;

  // strobes from control to datapath, one set per bus cycle
  typedef struct packed {
    logic   addrLoad;
    csAct_e csAct;
    logic   rdSet;
    logic   wrSet;
  } ctrlStrobes_t;

endpackage

// File: rtl/ebcs_ctrl.sv
module ebcs_ctrl
  import ebcs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NUM_CS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reqValid,
  input  logic [1:0]                 reqKind,
  input  logic [ADDR_W-1:0]          reqAddr,
  output ctrlStrobes_t               strobes,
  output logic [$clog2(NUM_CS)-1:0]  spaceSel
);
  localparam int SEL_W = $clog2(NUM_CS);

  reqKind_e   kindEff;
  logic [SEL_W-1:0] spaceNow;
  logic       lastValid;
  logic [SEL_W-1:0] lastSpace;
  logic       lastValidNext;
  logic [SEL_W-1:0] lastSpaceNext;

  assign kindEff  = reqValid ? reqKind_e'(reqKind) : KIND_NONE;
  assign spaceNow = reqAddr[ADDR_W-1 -: SEL_W];
  assign spaceSel = spaceNow;

  always_comb begin
    strobes       = '{addrLoad: 1'b0, csAct: CS_HOLD, rdSet: 1'b0, wrSet: 1'b0};
    lastValidNext = lastValid;
    lastSpaceNext = lastSpace;
    unique case (kindEff)
      KIND_NONE: ;
      KIND_INT: begin
        strobes.csAct = CS_CLEAR;
        lastValidNext = 1'b0;
      end
      KIND_EXT_RD, KIND_EXT_WR: begin
        strobes.addrLoad = 1'b1;
        strobes.rdSet    = (kindEff == KIND_EXT_RD);
        strobes.wrSet    = (kindEff == KIND_EXT_WR);
        if (lastValid && (lastSpace == spaceNow)) strobes.csAct = CS_HOLD;
        else                                      strobes.csAct = CS_SELECT;
        lastValidNext = 1'b1;
        lastSpaceNext = spaceNow;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastValid <= 1'b0;
      lastSpace <= '0;
    end else begin
      lastValid <= lastValidNext;
      lastSpace <= lastSpaceNext;
    end
  end

endmodule

// File: rtl/ebcs_datapath.sv
module ebcs_datapath
  import ebcs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NUM_CS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrlStrobes_t               strobes,
  input  logic [$clog2(NUM_CS)-1:0]  spaceSel,
  input  logic [ADDR_W-1:0]          reqAddr,
  output logic [ADDR_W-1:0]          busAddr,
  output logic [NUM_CS-1:0]          csN,
  output logic                       rdStrobe,
  output logic                       wrStrobe
);
  localparam int SEL_W = $clog2(NUM_CS);

  always_ff @(posedge clk) begin
    if (rst) begin
      busAddr  <= '0;
      rdStrobe <= 1'b0;
      wrStrobe <= 1'b0;
    end else begin
      if (strobes.addrLoad) busAddr <= reqAddr;
      rdStrobe <= strobes.rdSet;
      wrStrobe <= strobes.wrSet;
    end
  end

  // one flop per chip-select line, each deciding on its own
  for (genvar g = 0; g < NUM_CS; g++) begin : gCsLine
    always_ff @(posedge clk) begin
      if (rst) begin
        csN[g] <= 1'b1;
      end else begin
        unique case (strobes.csAct)
          CS_CLEAR:  csN[g] <= 1'b1;
          CS_SELECT: csN[g] <= (spaceSel != SEL_W'(g));
          default:   csN[g] <= csN[g];
        endcase
      end
    end
  end

endmodule

// File: rtl/extbus_cs_seq.sv
module extbus_cs_seq
  import ebcs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [NUM_CS-1:0] csN,
  output logic              rdStrobe,
  output logic              wrStrobe
);
  localparam int SEL_W = $clog2(NUM_CS);

  ctrlStrobes_t     strobes;
  logic [SEL_W-1:0] spaceSel;

  ebcs_ctrl #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) uCtrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .strobes(strobes), .spaceSel(spaceSel)
  );

  ebcs_datapath #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .spaceSel(spaceSel),
    .reqAddr(reqAddr), .busAddr(busAddr), .csN(csN),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe)
  );

endmodule

// File: rtl/extbus_cs_seq_chk.sv
module extbus_cs_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [NUM_CS-1:0] csN,
  input logic              rdStrobe,
  input logic              wrStrobe
);
  localparam int SEL_W = $clog2(NUM_CS);

  // R2
  ext_loads_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqKind[1]) |=> (busAddr == $past(reqAddr)) &&
      !csN[$past(reqAddr[ADDR_W-1 -: SEL_W])]);

  // R3
  same_space_no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqKind[1] && !csN[reqAddr[ADDR_W-1 -: SEL_W]])
      |=> $stable(csN));

  // R5
  internal_frees_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqKind == 2'b01) |=> (&csN) && $stable(busAddr));

  // R6
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!reqValid || reqKind == 2'b00) |=> $stable(busAddr) && $stable(csN));

  // R7
  one_cs_max_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~csN));

  // R8
  rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqKind == 2'b10) |=> rdStrobe && !wrStrobe);

  // R8
  wr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqKind == 2'b11) |=> wrStrobe && !rdStrobe);

  // R8
  no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!reqValid || !reqKind[1]) |=> !rdStrobe && !wrStrobe);

endmodule

bind extbus_cs_seq extbus_cs_seq_chk #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) uChk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind),
  .reqAddr(reqAddr), .busAddr(busAddr), .csN(csN),
  .rdStrobe(rdStrobe), .wrStrobe(wrStrobe)
);

// File: tb/tb_extbus_cs_seq.sv
module tb_extbus_cs_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'b00;
  logic [23:0] reqAddr = '0;
  logic [23:0] busAddr;
  logic [3:0]  csN;
  logic        rdStrobe, wrStrobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [23:0] mAddr = '0;
  int          mSpace = -1;
  bit          mRd = 1'b0, mWr = 1'b0;
  string       mTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  extbus_cs_seq dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .busAddr(busAddr), .csN(csN),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] expCsN();
    logic [3:0] v = 4'b1111;
    if (mSpace >= 0) v[mSpace] = 1'b0;
    return v;
  endfunction

  task automatic compareAll();
    chk(mTag, "busAddr", 32'(busAddr), 32'(mAddr));
    chk(mTag, "csN", 32'(csN), 32'(expCsN()));
    chk("R7", "lowCount<=1", 32'($countones(~csN) <= 1), 32'd1);
    chk("R8", "strobes", {30'd0, rdStrobe, wrStrobe}, {30'd0, mRd, mWr});
  endtask

  // called at a negedge: apply request, advance model, check at the next negedge
  task automatic step(bit v, logic [1:0] k, logic [23:0] a);
    int kk;
    int s;
    reqValid = v; reqKind = k; reqAddr = a;
    kk = v ? int'(k) : 0;
    s  = int'(a[23:22]);
    mRd = 1'b0; mWr = 1'b0;
    case (kk)
      0: mTag = "R6";
      1: begin mTag = "R5"; mSpace = -1; end
      default: begin
        mTag = (mSpace < 0) ? "R2" : ((mSpace == s) ? "R3" : "R4");
        mSpace = s; mAddr = a;
        mRd = (kk == 2); mWr = (kk == 3);
      end
    endcase
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    mTag = "R1";
    compareAll();
    rst = 1'b0;
    step(1'b0, 2'b00, 24'h000000);           // R1 idle after reset: still nothing selected
    step(1'b1, 2'b00, 24'h123456);           // R6 idle kind, no region selected
    step(1'b1, 2'b10, 24'h401234);           // R2 region 1, read
    step(1'b1, 2'b11, 24'h405678);           // R3 same region, write
    step(1'b1, 2'b00, 24'hFFFFFF);           // R6 idle keeps region 1
    step(1'b0, 2'b11, 24'hC00000);           // R6 invalid external ignored
    step(1'b1, 2'b10, 24'h7FFFFF);           // R3 same region after idles
    step(1'b1, 2'b11, 24'hC00001);           // R4 switch to region 3
    step(1'b1, 2'b01, 24'h000000);           // R5 internal frees CS, addr held
    step(1'b1, 2'b00, 24'h800000);           // R6 idle after internal stays free
    step(1'b1, 2'b10, 24'hC00002);           // R2 back to region 3 after internal
    step(1'b1, 2'b10, 24'h000010);           // R4 region 0
    step(1'b1, 2'b11, 24'h800020);           // R4 region 2
    step(1'b1, 2'b01, 24'h400000);           // R5
    step(1'b1, 2'b01, 24'h400000);           // R5 internal twice
    for (int i = 0; i < 2000; i++) begin
      logic [1:0]  rk;
      logic [23:0] ra;
      bit          rv;
      rv = ($urandom_range(0, 7) != 0);
      rk = 2'($urandom_range(0, 3));
      ra = {2'($urandom_range(0, 3)), 22'($urandom)};
      step(rv, rk, ra);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule